// File: doc/BRIEF.md
# Adaptive Biphase-Mark Line Decoder

This block recovers data bits from a biphase-mark serial line, such as the configuration channel of a USB Power Delivery link. It runs on a system clock that is many times faster than the bit rate. The line passes through a two-flop synchronizer. A counter then measures the clock cycles between successive transitions. A control state machine sorts each measured interval as a half-bit or a full-bit interval.

The half/full decision point is not fixed. It follows a four-tap, equal-weight moving average of the most recent full-bit periods. This lets the decoder ride through slow drift in the sender's clock, and also through a single bit whose period jumps abruptly. The encoding rule is as follows. Every bit boundary carries a transition. A one has a second transition at mid-bit, and a zero has none.

Interval patterns that cannot be legal biphase-mark data are reported on two error strobes. A long silence sends the decoder to a sleep state in which its counter and state are frozen. The next transition wakes it, and the first full bit after that reloads the average. The decoded-bit output has no back-pressure. `bit_valid_o` has no ready partner, because the line cannot be stalled. A consumer must take `bit_o` in the one cycle it is offered.

Top module: `bmc_rx_decoder`

## Requirements
- R1: After reset, `sleep_o` is 1 and `bit_valid_o`, `frame_err_o` and `glitch_err_o` are 0. They stay so while `line_i` does not change.
- R2: Let S be the sum of the four stored full-bit periods and T = floor(3*S/16). An interval of at least T cycles decodes as a 0 (`bit_o` = 0). Two successive intervals each shorter than T decode as a single 1 (`bit_o` = 1).
- R3: Every decoded bit, frame error or glitch error is a one-cycle pulse. It is visible after the third rising clock edge following the `line_i` transition that closes it. At most one of the three strobes is high in any cycle.
- R4: The first interval after leaving sleep is taken as a full-bit 0 and emitted as such. Its length is loaded into all four filter taps.
- R5: Each decoded bit shifts its full period into the filter and drops the oldest tap. For a 1, the full period is the sum of its two half intervals, saturated to the counter range.
- R6: With the average steady, a single bit whose period is up to 25% longer or shorter still decodes to its correct value. This holds for both zeros and ones.
- R7: Thirteen consecutive bits whose period differs from the tracked period by up to ±7.13% all decode correctly.
- R8: A short interval followed by an interval of at least T pulses `frame_err_o` and emits no bit. The closing transition of the long interval becomes the next bit boundary.
- R9: An interval shorter than floor(S/16) pulses `glitch_err_o` and emits no bit. Its closing transition becomes the next bit boundary.
- R10: While decoding, if the interval count exceeds floor(S/2), `sleep_o` rises on the following clock edge. In sleep, the counter and state hold until the next transition. An acquisition interval that reaches the counter maximum (2^CNT_W-1) also returns the decoder to sleep.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Asynchronous biphase-mark line |
| bit_o | output | 1 | Decoded bit value, meaningful while `bit_valid_o` is 1 |
| bit_valid_o | output | 1 | One-cycle strobe for `bit_o`; no ready |
| frame_err_o | output | 1 | One-cycle strobe: half interval followed by a full interval |
| glitch_err_o | output | 1 | One-cycle strobe: interval too short for any legal bit |
| sleep_o | output | 1 | 1 while the decoder is idle and gated off |

## Verification
Each bit strobe and error strobe is due exactly three rising edges after the transition that closes the interval. The bench records that due cycle at the moment it drives each transition. A monitor samples every falling edge and pairs each strobe it sees, in order, with the event owed at that cycle. Any early, late, extra or missing strobe is therefore reported. The entry to sleep is due on the edge after the interval count first exceeds twice the average. It is probed one cycle before and on that edge, with the count taken from the last transition driven.

// File: rtl/bmcd_pkg.sv
package bmcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_RUN  = 2'd2,
    ST_HALF = 2'd3
  } bmcd_state_e;
endpackage

// File: rtl/bmcd_sync_edge.sv
module bmcd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/bmcd_interval_cnt.sv
module bmcd_interval_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (edge_i)
      cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (run_i && (cnt_q != '1))
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_FROZEN_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !edge_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/bmcd_period_fir.sv
module bmcd_period_fir #(
  parameter int CNT_W = 8,
  parameter int TAPS  = 4,
  localparam int TAP_W = $clog2(TAPS),
  localparam int SUM_W = CNT_W + TAP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             push_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [CNT_W-1:0] taps_q [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                taps_q[g] <= '0;
        else if (load_i || push_i) taps_q[g] <= period_i;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      taps_q[g] <= '0;
        else if (load_i) taps_q[g] <= period_i;
        else if (push_i) taps_q[g] <= taps_q[g-1];
      end
    end
  end

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < TAPS; i++)
      sum_o = sum_o + {{TAP_W{1'b0}}, taps_q[i]};
  end

  AST_RELOAD_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (taps_q[0] == taps_q[TAPS-1])); // R4

  if (TAPS > 1) begin : g_shift_chk
    AST_PUSH_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !load_i) |=> (taps_q[1] == $past(taps_q[0]))); // R5
  end
endmodule

// File: rtl/bmcd_ctrl.sv
module bmcd_ctrl
  import bmcd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TAPS  = 4,
  localparam int TAP_W = $clog2(TAPS),
  localparam int SUM_W = CNT_W + TAP_W,
  localparam int CMP_W = SUM_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic             run_o,
  output logic             load_o,
  output logic             push_o,
  output logic [CNT_W-1:0] period_o,
  output logic             bit_o,
  output logic             valid_o,
  output logic             ferr_o,
  output logic             gerr_o,
  output logic             sleep_o
);
  bmcd_state_e      state_q, state_d;
  logic [CNT_W-1:0] half_q, half_d;
  logic             bit_q, bit_d, valid_q, valid_d;
  logic             ferr_q, ferr_d, gerr_q, gerr_d;

  logic [CMP_W-1:0] cnt_x, sum3, thr, glim, ilim;
  logic [CNT_W:0]   hsum;
  logic             is_short, is_glitch, timeout;

  // decision points derived from the filtered sum
  assign cnt_x     = {{(CMP_W-CNT_W){1'b0}}, cnt_i};
  assign sum3      = {2'b00, sum_i} + {1'b0, sum_i, 1'b0};
  assign thr       = sum3 >> (TAP_W + 2);
  assign glim      = {2'b00, sum_i} >> (TAP_W + 2);
  assign ilim      = {1'b0, sum_i, 1'b0} >> TAP_W;
  assign is_short  = cnt_x < thr;
  assign is_glitch = cnt_x < glim;
  assign timeout   = (cnt_x > ilim) || (cnt_i == '1);
  assign hsum      = {1'b0, half_q} + {1'b0, cnt_i};

  always_comb begin
    state_d  = state_q;
    half_d   = half_q;
    load_o   = 1'b0;
    push_o   = 1'b0;
    period_o = cnt_i;
    bit_d    = 1'b0;
    valid_d  = 1'b0;
    ferr_d   = 1'b0;
    gerr_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (edge_i) state_d = ST_ACQ;
      ST_ACQ: begin
        if (edge_i) begin
          load_o  = 1'b1;
          valid_d = 1'b1;
          state_d = ST_RUN;
        end else if (cnt_i == '1) begin
          state_d = ST_IDLE;
        end
      end
      ST_RUN: begin
        if (edge_i) begin
          if (is_glitch) begin
            gerr_d = 1'b1;
          end else if (!is_short) begin
            valid_d = 1'b1;
            push_o  = 1'b1;
          end else begin
            half_d  = cnt_i;
            state_d = ST_HALF;
          end
        end else if (timeout) begin
          state_d = ST_IDLE;
        end
      end
      ST_HALF: begin
        if (edge_i) begin
          state_d = ST_RUN;
          if (is_glitch) begin
            gerr_d = 1'b1;
          end else if (!is_short) begin
            ferr_d = 1'b1;
          end else begin
            valid_d  = 1'b1;
            bit_d    = 1'b1;
            push_o   = 1'b1;
            period_o = hsum[CNT_W] ? '1 : hsum[CNT_W-1:0];
          end
        end else if (timeout) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      gerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      gerr_q  <= gerr_d;
    end
  end

  assign run_o   = (state_q != ST_IDLE);
  assign sleep_o = (state_q == ST_IDLE);
  assign bit_o   = bit_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
  assign gerr_o  = gerr_q;

  AST_STROBE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q || ferr_q || gerr_q) |-> $past(edge_i)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_q, ferr_q, gerr_q})); // R3
  AST_FRAME_FROM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> ($past(state_q) == ST_HALF)); // R8
  AST_ONE_NEEDS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && bit_q) |-> ($past(state_q) == ST_HALF)); // R2
  AST_ASLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !edge_i) |=> (state_q == ST_IDLE)); // R10
endmodule

// File: rtl/bmc_rx_decoder.sv
module bmc_rx_decoder #(
  parameter int CNT_W       = 8,
  parameter int TAPS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic bit_o,
  output logic bit_valid_o,
  output logic frame_err_o,
  output logic glitch_err_o,
  output logic sleep_o
);
  localparam int TAP_W = $clog2(TAPS);
  localparam int SUM_W = CNT_W + TAP_W;

  logic             edge_w, run_w, load_w, push_w;
  logic [CNT_W-1:0] cnt_w, period_w;
  logic [SUM_W-1:0] sum_w;

  bmcd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .edge_o(edge_w)
  );

  bmcd_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .run_i(run_w), .cnt_o(cnt_w)
  );

  bmcd_period_fir #(.CNT_W(CNT_W), .TAPS(TAPS)) u_fir (
    .clk(clk), .rst_n(rst_n), .load_i(load_w), .push_i(push_w),
    .period_i(period_w), .sum_o(sum_w)
  );

  bmcd_ctrl #(.CNT_W(CNT_W), .TAPS(TAPS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_w), .cnt_i(cnt_w), .sum_i(sum_w),
    .run_o(run_w), .load_o(load_w), .push_o(push_w), .period_o(period_w),
    .bit_o(bit_o), .valid_o(bit_valid_o), .ferr_o(frame_err_o),
    .gerr_o(glitch_err_o), .sleep_o(sleep_o)
  );

  AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> !(bit_valid_o || frame_err_o || glitch_err_o)); // R10
endmodule

// File: tb/bmc_rx_decoder_bench.sv
`timescale 1ns/1ps
module bmc_rx_decoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic bit_o, bit_valid_o, frame_err_o, glitch_err_o, sleep_o;

  always #2 clk = ~clk;

  bmc_rx_decoder u_bmc_rx_decoder (
    .clk(clk), .rst_n(rst_n), .line_i(line), .bit_o(bit_o),
    .bit_valid_o(bit_valid_o), .frame_err_o(frame_err_o),
    .glitch_err_o(glitch_err_o), .sleep_o(sleep_o)
  );

  // packet vectors: {period[23:16], data bit count[15:12], data LSB first[11:0]}
  localparam int NV = 7;
  localparam logic [23:0] VEC [NV] = '{
    24'h28_8_0A5, 24'h18_C_F0F, 24'h40_A_2D3, 24'h64_6_02B,
    24'h10_C_9C6, 24'h32_C_000, 24'h20_C_FFF
  };

  int    cyc = 0;
  int    nchk = 0;
  int    nerr = 0;
  int    pend = 0;   // event owed at the next boundary: 0 none, 1 zero, 2 one, 3 frame, 4 glitch
  int    exp_q[$];
  string req = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int ex);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", r, what, act, ex, cyc);
    end
  endtask

  // pairs each observed strobe with the event owed, checking kind and due cycle
  always @(negedge clk) begin
    if (rst_n) begin
      int kind;
      kind = bit_valid_o ? (bit_o ? 2 : 1) : frame_err_o ? 3 : glitch_err_o ? 4 : 0;
      if (kind != 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, req, "unexpected strobe kind", kind, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(kind == e % 8, req, "strobe kind", kind, e % 8);
          chk(cyc == e / 8, req, "strobe cycle", cyc, e / 8);
        end
      end
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tog();
    line = ~line;
  endtask

  task automatic boundary();
    tog();
    if (pend != 0) exp_q.push_back((cyc + 3) * 8 + pend);
    pend = 0;
  endtask

  task automatic send_bit(input bit b, input int p);
    boundary();
    if (b) begin
      waitn(p / 2); tog(); waitn(p - p / 2);
    end else begin
      waitn(p);
    end
    pend = b ? 2 : 1;
  endtask

  task automatic send_split_one(input int h1, input int h2);
    boundary(); waitn(h1); tog(); waitn(h2);
    pend = 2;
  endtask

  task automatic send_bad_half(input int p);
    boundary(); waitn(p / 2); tog(); waitn(p);
    pend = 3;
  endtask

  task automatic send_glitch(input int g, input int p);
    boundary(); waitn(g); tog();
    exp_q.push_back((cyc + 3) * 8 + 4);
    waitn(p);
    pend = 1;
  endtask

  task automatic preamble(input int n, input int p);
    for (int i = 0; i < n; i++) send_bit(i % 2 == 1, p);
  endtask

  task automatic drain(input string r);
    waitn(6);
    chk(exp_q.size() == 0, r, "strobes still owed", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // closes the packet, then probes the sleep entry edge (all four taps equal p)
  task automatic end_and_sleep(input int p);
    int t;
    boundary();
    t = cyc;
    while (cyc < t + 3 + 2 * p) @(negedge clk);
    chk(sleep_o == 1'b0, "R10", "sleep one cycle early", sleep_o, 0);
    @(negedge clk);
    chk(sleep_o == 1'b1, "R10", "sleep on limit edge", sleep_o, 1);
    drain("R10");
  endtask

  task automatic end_loose(input string r);
    boundary();
    waitn(300);
    chk(sleep_o == 1'b1, r, "asleep after packet", sleep_o, 1);
    drain(r);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state and quiet line
    repeat (5) @(negedge clk);
    chk(sleep_o == 1'b1, "R1", "sleep in reset", sleep_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sleep_o == 1'b1, "R1", "sleep after reset", sleep_o, 1);
    chk(bit_valid_o == 1'b0, "R1", "valid after reset", bit_valid_o, 0);
    chk(frame_err_o == 1'b0, "R1", "frame error after reset", frame_err_o, 0);
    chk(glitch_err_o == 1'b0, "R1", "glitch error after reset", glitch_err_o, 0);
    waitn(50);
    chk(sleep_o == 1'b1, "R1", "sleep on steady line", sleep_o, 1);

    // R2 R3 R4: packets from the vector table, each preceded by a 0101 preamble
    req = "R2 R3 R4";
    for (int v = 0; v < NV; v++) begin
      int p, n;
      logic [11:0] d;
      p = int'(VEC[v][23:16]);
      n = int'(VEC[v][15:12]);
      d = VEC[v][11:0];
      preamble(4, p);
      for (int i = 0; i < n; i++) send_bit(d[i], p);
      end_and_sleep(p);
      waitn(20);
    end

    // R6: single abrupt bits at 125% and 75% of a steady 40-cycle period
    req = "R6";
    preamble(6, 40);
    send_bit(1'b0, 50); preamble(4, 40);
    send_bit(1'b0, 30); preamble(4, 40);
    send_bit(1'b1, 50); preamble(4, 40);
    send_bit(1'b1, 30); preamble(4, 40);
    end_loose("R6");

    // R7: thirteen bits 7% slow, then thirteen bits 7% fast
    req = "R7";
    preamble(4, 100);
    for (int i = 0; i < 13; i++) send_bit(i % 3 == 0, 107);
    end_loose("R7");
    preamble(4, 100);
    for (int i = 0; i < 13; i++) send_bit(i % 3 != 1, 93);
    end_loose("R7");

    // R5: after four 56-cycle zeros, 40-cycle halves fall below the new threshold
    req = "R5";
    preamble(4, 40);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 56);
    send_split_one(40, 40);
    send_bit(1'b0, 56);
    end_loose("R5");

    // R8 R9: frame error, then a glitch, each followed by good bits
    req = "R8 R9";
    preamble(4, 40);
    send_bad_half(40);
    send_bit(1'b1, 40);
    send_bit(1'b0, 40);
    send_glitch(5, 40);
    send_bit(1'b1, 40);
    end_loose("R8 R9");

    // R10: a lone transition wakes the decoder, then acquisition saturates
    req = "R10";
    begin
      int t;
      tog();
      t = cyc;
      while (cyc < t + 4) @(negedge clk);
      chk(sleep_o == 1'b0, "R10", "awake after transition", sleep_o, 0);
      waitn(300);
      chk(sleep_o == 1'b1, "R10", "asleep after acquisition overflow", sleep_o, 1);
    end
    req = "R4 R10";
    preamble(4, 40);
    send_bit(1'b1, 40);
    end_and_sleep(40);

    summary();
    $finish;
  end
endmodule